// File: doc/BRIEF.md
# Parallel LCD Bus Cycle Engine

This block sits on the host side of a character-display module that uses a parallel bus with a register-select line, a read/write line, an active-high enable strobe and an 8-bit bidirectional data bus. A client hands it one transfer at a time over a valid/ready handshake. Each transfer carries the register-select value, the direction and the write byte. The engine then runs one complete bus cycle. It places register-select and direction, opens or releases the data drivers, raises the enable strobe for a measured width, and lowers it to complete the transfer. It then holds the lines for the hold window and waits out the remaining cycle time before it takes another request.

Every interval is a parameter in nanoseconds, together with the system clock period. The engine rounds each interval up to whole clocks. The enable-high width is the largest of three values: the minimum pulse width, the write-data setup to the falling edge, and the read access delay plus one clock. On a read, the bus is sampled in the last clock before the enable strobe falls. The byte comes back with a one-clock completion pulse. Splitting bytes into nibbles and sequencing display commands belong to the client.

Top module: `lcd_bus_engine`

## Requirements
- R1: While and just after reset, the enable strobe and the data output-enable are low, the completion pulse is low and the engine is ready.
- R2: A request is taken on a clock where valid and ready are both high. Ready stays low from that clock until the cycle-time recovery has ended. A valid raised while ready is low starts no bus cycle and produces no completion.
- R3: The enable strobe stays high for exactly HIGH clocks. HIGH is the largest of: pulse width rounded up, write-data setup rounded up, and read access delay rounded up plus one. With the defaults (4 ns clock) this is 35 clocks.
- R4: Register-select and direction (1 = read) take the requested values at least one clock before the enable strobe rises. They stay unchanged while the strobe is high and through the hold window after it falls.
- R5: On a write, the output-enable is high and the data output equals the request byte from the setup phase onward. Both remain until HOLD clocks after the strobe falls. HOLD is the larger hold time rounded up, at least one; it is 3 clocks with the defaults.
- R6: On a read, the output-enable stays low for the whole cycle. The read byte is the bus value in the last clock the strobe is high.
- R7: Two consecutive rising edges of the enable strobe are at least the cycle time rounded up apart, which is 300 clocks with the defaults.
- R8: The completion pulse lasts one clock. It comes SETUP+HIGH+HOLD+1 clocks after the accepting clock, which is 40 with the defaults. A write leaves the read-data output unchanged.
- R9: Both register-select values (0 = instruction side, 1 = data side) are carried to the bus pin unchanged, in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Engine can take a request |
| reqRs | input | 1 | Register-select value for the cycle |
| reqRead | input | 1 | 1 = read cycle, 0 = write cycle |
| reqWdata | input | 8 | Byte to write |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Byte captured by the latest read |
| lcdRs | output | 1 | Register-select pin |
| lcdRw | output | 1 | Read/write pin (1 = read) |
| lcdE | output | 1 | Enable strobe pin, active high |
| lcdDataOut | output | 8 | Data driven toward the display |
| lcdDataOe | output | 1 | Output enable for the data pins |
| lcdDataIn | input | 8 | Data returned by the display |

## Verification
Writes and reads are issued with register-select at both 0 and 1 and with distinct bytes, so that a swapped select, a swapped direction or a stale byte shows up on the pins. A display model returns a filler byte until the access delay has passed and the true byte after it, so sampling too early reads the filler. Back-to-back transfers check the spacing of successive strobe edges. A request raised during a busy cycle must leave the strobe count and the completion pulse unchanged. A write placed between reads must leave the read-data output alone.

// File: rtl/lcd_bus_pkg.sv
package lcd_bus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_HIGH,
    PH_HOLD,
    PH_GAP
  } phase_t;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic load;     // take the request fields
    logic enable;   // registered strobe level
    logic window;   // setup/high/hold span of the current cycle
    logic capture;  // last clock of strobe high
    logic finish;   // last clock of hold
  } strobe_t;

  function automatic int nsToCycles(input int ns, input int periodNs);
    return (ns + periodNs - 1) / periodNs;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lcd_bus_ctrl.sv
module lcd_bus_ctrl
  import lcd_bus_pkg::*;
#(
  parameter int CLK_NS        = 4,
  parameter int CYCLE_NS      = 1200,
  parameter int PULSE_NS      = 140,
  parameter int ADDR_SETUP_NS = 0,
  parameter int ADDR_HOLD_NS  = 10,
  parameter int DATA_SETUP_NS = 40,
  parameter int DATA_HOLD_NS  = 10,
  parameter int READ_DELAY_NS = 100
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    reqValid,
  output logic    reqReady,
  output strobe_t strobe
);

  localparam int SETUP_CYC = maxOf(1, nsToCycles(ADDR_SETUP_NS, CLK_NS));
  localparam int HIGH_CYC  = maxOf(maxOf(nsToCycles(PULSE_NS, CLK_NS),
                                         nsToCycles(DATA_SETUP_NS, CLK_NS)),
                                   nsToCycles(READ_DELAY_NS, CLK_NS) + 1);
  localparam int HOLD_CYC  = maxOf(1, nsToCycles(maxOf(ADDR_HOLD_NS, DATA_HOLD_NS), CLK_NS));
  localparam int BASE_CYC  = SETUP_CYC + HIGH_CYC + HOLD_CYC + 1;
  localparam int CYCLE_CYC = maxOf(nsToCycles(CYCLE_NS, CLK_NS), BASE_CYC);
  localparam int GAP_CYC   = CYCLE_CYC - BASE_CYC;
  localparam int CNT_W     = $clog2(CYCLE_CYC + 1);
  localparam bit HAS_GAP   = (GAP_CYC > 0);

  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] HIGH_LD  = CNT_W'(HIGH_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_LD   = CNT_W'(HAS_GAP ? GAP_CYC - 1 : 0);

  phase_t phase, phaseNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic enableQ, windowQ;
  logic cntZero;

  assign cntZero = (cnt == '0);

  always_comb begin
    phaseNext = phase;
    cntNext   = cntZero ? cnt : cnt - 1'b1;
    unique case (phase)
      PH_IDLE: begin
        if (reqValid) begin
          phaseNext = PH_SETUP;
          cntNext   = SETUP_LD;
        end
      end
      PH_SETUP: begin
        if (cntZero) begin
          phaseNext = PH_HIGH;
          cntNext   = HIGH_LD;
        end
      end
      PH_HIGH: begin
        if (cntZero) begin
          phaseNext = PH_HOLD;
          cntNext   = HOLD_LD;
        end
      end
      PH_HOLD: begin
        if (cntZero) begin
          phaseNext = HAS_GAP ? PH_GAP : PH_IDLE;
          cntNext   = GAP_LD;
        end
      end
      PH_GAP: begin
        if (cntZero) phaseNext = PH_IDLE;
      end
      default: begin
        phaseNext = PH_IDLE;
        cntNext   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      enableQ <= 1'b0;
      windowQ <= 1'b0;
    end else begin
      phase   <= phaseNext;
      cnt     <= cntNext;
      enableQ <= (phaseNext == PH_HIGH);
      windowQ <= (phaseNext == PH_SETUP) || (phaseNext == PH_HIGH) || (phaseNext == PH_HOLD);
    end
  end

  assign reqReady       = (phase == PH_IDLE);
  assign strobe.load    = (phase == PH_IDLE) && reqValid;
  assign strobe.enable  = enableQ;
  assign strobe.window  = windowQ;
  assign strobe.capture = (phase == PH_HIGH) && cntZero;
  assign strobe.finish  = (phase == PH_HOLD) && cntZero;

  // Checker state: clocks since the previous rising strobe edge.
  logic [CNT_W-1:0] sinceRise;
  logic enPrev, seenRise;
  always_ff @(posedge clk) begin
    if (rst) begin
      sinceRise <= '0;
      enPrev    <= 1'b0;
      seenRise  <= 1'b0;
    end else begin
      enPrev <= enableQ;
      if (enableQ && !enPrev) begin
        sinceRise <= CNT_W'(1);
        seenRise  <= 1'b1;
      end else if (sinceRise != CNT_W'(CYCLE_CYC)) begin
        sinceRise <= sinceRise + 1'b1;
      end
    end
  end

  a_r7_cycle_time: assert property (@(posedge clk) disable iff (rst)
    (enableQ && !enPrev && seenRise) |-> (sinceRise >= CNT_W'(CYCLE_CYC)));

  a_r2_busy_no_ready: assert property (@(posedge clk) disable iff (rst)
    windowQ |-> !reqReady);

endmodule

// File: rtl/lcd_bus_dpath.sv
module lcd_bus_dpath
  import lcd_bus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobe,
  input  logic              reqRs,
  input  logic              reqRead,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] lcdDataIn,
  output logic              lcdRs,
  output logic              lcdRw,
  output logic              lcdE,
  output logic [DATA_W-1:0] lcdDataOut,
  output logic              lcdDataOe,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);

  logic              rsQ, rwQ, doneQ;
  logic [DATA_W-1:0] wdataQ, rdataQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsQ    <= 1'b0;
      rwQ    <= 1'b0;
      wdataQ <= '0;
      rdataQ <= '0;
      doneQ  <= 1'b0;
    end else begin
      if (strobe.load) begin
        rsQ    <= reqRs;
        rwQ    <= reqRead;
        wdataQ <= reqWdata;
      end
      if (strobe.capture && rwQ) rdataQ <= lcdDataIn;
      doneQ <= strobe.finish;
    end
  end

  assign lcdRs      = rsQ;
  assign lcdRw      = rwQ;
  assign lcdE       = strobe.enable;
  assign lcdDataOut = wdataQ;
  assign lcdDataOe  = strobe.window && !rwQ;
  assign done       = doneQ;
  assign rdata      = rdataQ;

  // R4 / R5: bus fields frozen across the whole setup/high/hold span.
  a_r4_fields_frozen: assert property (@(posedge clk) disable iff (rst)
    (strobe.window && $past(strobe.window)) |-> ($stable(rsQ) && $stable(rwQ) && $stable(wdataQ)));

  a_r4_hold_after_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(strobe.enable) |-> ($stable(rsQ) && $stable(rwQ) && strobe.window));

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    doneQ |=> !doneQ);

  a_r8_write_keeps_rdata: assert property (@(posedge clk) disable iff (rst)
    (strobe.window && !rwQ) |=> $stable(rdataQ));

endmodule

// File: rtl/lcd_bus_engine.sv
module lcd_bus_engine
  import lcd_bus_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int CLK_NS        = 4,
  parameter int CYCLE_NS      = 1200,
  parameter int PULSE_NS      = 140,
  parameter int ADDR_SETUP_NS = 0,
  parameter int ADDR_HOLD_NS  = 10,
  parameter int DATA_SETUP_NS = 40,
  parameter int DATA_HOLD_NS  = 10,
  parameter int READ_DELAY_NS = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqRs,
  input  logic              reqRead,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              lcdRs,
  output logic              lcdRw,
  output logic              lcdE,
  output logic [DATA_W-1:0] lcdDataOut,
  output logic              lcdDataOe,
  input  logic [DATA_W-1:0] lcdDataIn
);

  strobe_t strobe;

  lcd_bus_ctrl #(
    .CLK_NS(CLK_NS), .CYCLE_NS(CYCLE_NS), .PULSE_NS(PULSE_NS),
    .ADDR_SETUP_NS(ADDR_SETUP_NS), .ADDR_HOLD_NS(ADDR_HOLD_NS),
    .DATA_SETUP_NS(DATA_SETUP_NS), .DATA_HOLD_NS(DATA_HOLD_NS),
    .READ_DELAY_NS(READ_DELAY_NS)
  ) ctrl_i (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady), .strobe(strobe)
  );

  lcd_bus_dpath #(.DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rst(rst), .strobe(strobe),
    .reqRs(reqRs), .reqRead(reqRead), .reqWdata(reqWdata), .lcdDataIn(lcdDataIn),
    .lcdRs(lcdRs), .lcdRw(lcdRw), .lcdE(lcdE), .lcdDataOut(lcdDataOut),
    .lcdDataOe(lcdDataOe), .done(done), .rdata(rdata)
  );

  a_r6_no_drive_on_read: assert property (@(posedge clk) disable iff (rst)
    (lcdE && lcdRw) |-> !lcdDataOe);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    reqReady |-> (!lcdE && !lcdDataOe));

endmodule

// File: tb/lcd_bus_engine_tb.sv
module lcd_bus_engine_tb_top;

  localparam int T_NS      = 4;
  localparam int SETUP_CYC = 1;
  localparam int HIGH_CYC  = 35;   // max(ceil(140/4), ceil(40/4), ceil(100/4)+1)
  localparam int HOLD_CYC  = 3;    // ceil(10/4)
  localparam int CYCLE_CYC = 300;  // ceil(1200/4)
  localparam int DLY_CYC   = 25;   // ceil(100/4)
  localparam int LATENCY   = SETUP_CYC + HIGH_CYC + HOLD_CYC + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0, reqRs = 1'b0, reqRead = 1'b0;
  logic [7:0] reqWdata = '0;
  logic reqReady, done, lcdRs, lcdRw, lcdE, lcdDataOe;
  logic [7:0] rdata, lcdDataOut;
  logic [7:0] lcdDataIn = 8'h5A;
  logic [7:0] modelByte = 8'h00;

  int checks = 0, failures = 0;
  int cyc = 0;

  always #(T_NS / 2) clk = ~clk;

  lcd_bus_engine dut_i (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqRs(reqRs), .reqRead(reqRead), .reqWdata(reqWdata), .done(done), .rdata(rdata),
    .lcdRs(lcdRs), .lcdRw(lcdRw), .lcdE(lcdE), .lcdDataOut(lcdDataOut),
    .lcdDataOe(lcdDataOe), .lcdDataIn(lcdDataIn)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor and display model, all at the falling clock edge.
  logic ePrev = 0, rsPrev = 0, rwPrev = 0, oePrev = 0;
  int riseCount = 0, lastRise = -1, lastPeriod = 0, highRun = 0, lastHighWidth = 0;
  int rsAtRise = 0, rwAtRise = 0, setupOk = 0, dataAtFall = 0, oeAtFall = 0;
  int postOeRun = 0, oeInRead = 0, frozenBad = 0, doneCount = 0;
  logic afterFall = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (done) doneCount++;
      if (lcdE && !ePrev) begin
        riseCount++;
        if (lastRise >= 0) lastPeriod = cyc - lastRise;
        lastRise  = cyc;
        highRun   = 0;
        rsAtRise  = int'(lcdRs);
        rwAtRise  = int'(lcdRw);
        setupOk   = (lcdRs == rsPrev && lcdRw == rwPrev) ? 1 : 0;
        postOeRun = 0;
        oeInRead  = 0;
        frozenBad = 0;
        afterFall = 0;
      end
      if (lcdE) begin
        highRun++;
        dataAtFall = int'(lcdDataOut);
        oeAtFall   = int'(lcdDataOe);
        if (ePrev && (lcdRs != rsPrev || lcdRw != rwPrev)) frozenBad = 1;
      end
      if (!lcdE && ePrev) begin
        lastHighWidth = highRun;
        afterFall = 1;
      end
      if (afterFall && !lcdE && lcdDataOe) postOeRun++;
      if (afterFall && !lcdDataOe) afterFall = 0;
      if (lcdRw && lcdDataOe) oeInRead = 1;
      lcdDataIn = (lcdE && highRun > DLY_CYC) ? modelByte : 8'h5A;
    end
    ePrev = lcdE; rsPrev = lcdRs; rwPrev = lcdRw; oePrev = lcdDataOe;
  end

  // Issue one transfer and check its timing and result.
  task automatic runCycle(input logic rs, input logic rd, input logic [7:0] wbyte,
                          input logic [7:0] rbyte, input string label);
    int lat;
    logic [7:0] rdBefore;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    rdBefore  = rdata;
    modelByte = rbyte;
    reqValid = 1'b1; reqRs = rs; reqRead = rd; reqWdata = wbyte;
    @(negedge clk);
    reqValid = 1'b0; reqWdata = ~wbyte;
    lat = 1;
    while (!done && lat < 2000) begin
      @(negedge clk);
      lat++;
    end
    check({"R8 latency ", label}, lat, LATENCY);
    check({"R3 strobe width ", label}, lastHighWidth, HIGH_CYC);
    check({"R9 rs at rise ", label}, rsAtRise, int'(rs));
    check({"R4 rw at rise ", label}, rwAtRise, int'(rd));
    check({"R4 setup stable ", label}, setupOk, 1);
    check({"R4 frozen while high ", label}, frozenBad, 0);
    if (rd) begin
      check({"R6 oe low on read ", label}, oeInRead, 0);
      check({"R6 read byte ", label}, int'(rdata), int'(rbyte));
    end else begin
      check({"R5 data at fall ", label}, dataAtFall, int'(wbyte));
      check({"R5 oe at fall ", label}, oeAtFall, 1);
      check({"R5 oe hold clocks ", label}, postOeRun, HOLD_CYC);
      check({"R8 write keeps rdata ", label}, int'(rdata), int'(rdBefore));
    end
    @(negedge clk);
    check({"R8 done one clock ", label}, int'(done), 0);
  endtask

  task automatic testReset();
    check("R1 strobe low", int'(lcdE), 0);
    check("R1 oe low", int'(lcdDataOe), 0);
    check("R1 done low", int'(done), 0);
    check("R1 ready high", int'(reqReady), 1);
  endtask

  task automatic testBackToBack();
    runCycle(1'b1, 1'b0, 8'h11, 8'h00, "b2b-a");
    runCycle(1'b1, 1'b0, 8'h22, 8'h00, "b2b-b");
    check("R7 rise spacing", (lastPeriod >= CYCLE_CYC) ? 1 : 0, 1);
  endtask

  task automatic testBusyIgnored();
    int risesBefore, donesBefore;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    risesBefore = riseCount;
    donesBefore = doneCount;
    reqValid = 1'b1; reqRs = 1'b0; reqRead = 1'b0; reqWdata = 8'h44;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (10) @(negedge clk);
    check("R2 ready low when busy", int'(reqReady), 0);
    reqValid = 1'b1; reqRs = 1'b1; reqWdata = 8'h99;
    repeat (3) @(negedge clk);
    reqValid = 1'b0;
    while (!reqReady) @(negedge clk);
    repeat (5) @(negedge clk);
    check("R2 one strobe only", riseCount - risesBefore, 1);
    check("R2 one done only", doneCount - donesBefore, 1);
    check("R2 busy request dropped rs", int'(lcdRs), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rst = 1'b0;
    @(negedge clk);
    testReset();
    runCycle(1'b0, 1'b0, 8'h38, 8'h00, "wr-rs0");
    runCycle(1'b1, 1'b0, 8'hC3, 8'h00, "wr-rs1");
    runCycle(1'b0, 1'b1, 8'h00, 8'h95, "rd-rs0");
    runCycle(1'b1, 1'b1, 8'h00, 8'h7E, "rd-rs1");
    runCycle(1'b1, 1'b0, 8'h0F, 8'h00, "wr-after-rd");
    check("R8 rdata kept after write", int'(rdata), 8'h7E);
    testBackToBack();
    testBusyIgnored();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(T_NS * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule